// File: doc/BRIEF.md
# Serial Cyclic-Code Multiplying Encoder

This block produces codewords of a non-separable (15,11) cyclic code by multiplying each data word by the generator polynomial G(X) = X^4 + X^3 + 1 in modulo-2 arithmetic. The multiplier is written 11001 with the X^4 coefficient first. The product is built bit-serially. A chain of four one-cycle delay registers keeps the recent input bits. A row of XOR taps adds together the copies that match the nonzero coefficients of G. In the resulting codeword, data and check information cannot be separated.

A `start` strobe opens a word and clears the delay chain. The block then accepts eleven data bits, least significant first, each qualified by `din_valid`. One product bit leaves on `code_out` in the same cycle as each accepted bit, with `code_valid` high. After the eleventh bit the block feeds four zero bits into the chain by itself. These flush cycles produce the four high-order product bits. The output word therefore spans fifteen valid cycles, lowest-order coefficient first.

Top module: `cyc_mul_enc`

## Requirements
- R1: While reset is held and until the first `start`, `code_valid` and `code_out` stay low.
- R2: A `start` clears all delay state, so a word's codeword does not depend on any earlier or aborted word.
- R3: Output bit j of a word equals d[j] XOR d[j-3] XOR d[j-4], where d[i] is the i-th accepted data bit (bit 0 first) and d is zero outside 0..10. This is the product with generator 11001 (X^4 + X^3 + 1).
- R4: Exactly eleven data bits are accepted per word. They are followed at once by four flush cycles that also assert `code_valid`, so fifteen valid bits are produced per word, after which the block idles.
- R5: In a cycle of the data phase where `din_valid` is low, `code_valid` is low and no state advances. The word resumes unchanged on the next valid bit.
- R6: `din` and `din_valid` have no effect while idle or during the flush cycles: `code_valid` stays low when idle, and the flush bits are computed with zero inputs.
- R7: A `start` during a word aborts it and opens a new one. `code_valid` is low in the `start` cycle itself.
- R8: Every completed 15-bit output word, taking the first output bit as coefficient X^0, is divisible by G(X), and so is each of its cyclic rotations.
- R9: Data 10001100101 (binary, MSB written first) yields codeword 110000100011101 (MSB written first).
- R10: `code_out` is low in every cycle where `code_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Opens a new word and clears the delay chain |
| din | input | 1 | Serial data bit, LSB first |
| din_valid | input | 1 | Qualifies `din` during the data phase |
| code_out | output | 1 | Serial product (codeword) bit, lowest order first |
| code_valid | output | 1 | High when `code_out` carries a codeword bit |

## Verification
A corrupted delay register shows on `code_out` within three or four accepted bits, once that register reaches an active tap. It then keeps disturbing the word until the flush has shifted it out, so the received 15-bit word is no longer a multiple of G. A wrong phase or bit count shows at once on `code_valid`: the run of valid cycles is shorter or longer than fifteen, or there is a valid pulse during a stall or while idle. State left over from an aborted word shows up only in the first four bits of the next word. For that reason a restart is followed by a word whose expected low-order bits differ from the aborted one.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_FLUSH = 2'd2
  } cme_phase_e;
endpackage

// File: rtl/cme_rst_sync.sv
module cme_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/cme_seq.sv
module cme_seq
  import cme_pkg::*;
#(
  parameter int DATA_W = 11,
  parameter int DEG    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       din_valid,
  output logic       clr,
  output logic       shift,
  output logic       feed_zero,
  output logic       last_flush,
  output cme_phase_e phase
);
  localparam int MAXC = (DATA_W > DEG) ? DATA_W : DEG;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  cme_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start) begin
      phase_d = PH_DATA;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (phase_q)
        PH_DATA: if (din_valid) begin
          cnt_en = 1'b1;
          if (cnt_q == CW'(DATA_W - 1)) begin
            phase_d = PH_FLUSH;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_FLUSH: begin
          cnt_en = 1'b1;
          if (cnt_q == CW'(DEG - 1)) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clr        = start;
  assign shift      = !start && (((phase_q == PH_DATA) && din_valid) || (phase_q == PH_FLUSH));
  assign feed_zero  = (phase_q == PH_FLUSH);
  assign last_flush = (phase_q == PH_FLUSH) && (cnt_q == CW'(DEG - 1));
  assign phase      = phase_q;

  // R4: the data-phase bit count never reaches the word length
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA) |-> (cnt_q < CW'(DATA_W)));

  // R4: the last flush cycle hands over to idle unless a new word opens
  p_flush_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_flush && !start) |=> (phase_q == PH_IDLE));

  // R7: a start always lands in the data phase with a fresh count
  p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase_q == PH_DATA && cnt_q == '0));
endmodule

// File: rtl/cme_tapline.sv
module cme_tapline #(
  parameter int               DEG = 4,
  parameter logic [DEG:0]     GEN = 5'b11001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         bit_in,
  output logic         bit_out,
  output logic [DEG:1] dly
);
  logic [DEG:1] dly_q, dly_d;
  logic         dly_en;
  logic [DEG:0] acc;

  always_comb begin
    dly_en = clr || shift;
    dly_d  = dly_q;
    if (clr) dly_d = '0;
    else if (shift) begin
      dly_d[1] = bit_in;
      for (int k = 2; k <= DEG; k++) dly_d[k] = dly_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_en) dly_q <= dly_d;
  end

  assign acc[0] = GEN[0] & bit_in;
  for (genvar k = 1; k <= DEG; k++) begin : g_tap
    assign acc[k] = acc[k-1] ^ (GEN[k] & dly_q[k]);
  end

  assign bit_out = acc[DEG];
  assign dly     = dly_q;
endmodule

// File: rtl/cyc_mul_enc.sv
module cyc_mul_enc
  import cme_pkg::*;
#(
  parameter int                   DATA_W   = 11,
  parameter int                   POLY_DEG = 4,
  parameter logic [POLY_DEG:0]    GEN_POLY = 5'b11001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic din,
  input  logic din_valid,
  output logic code_out,
  output logic code_valid
);
  logic              rst_sync_n;
  logic              clr, shift, feed_zero, last_flush, tap_out, line_in;
  logic [POLY_DEG:1] dly;
  cme_phase_e        phase;

  cme_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  cme_seq #(.DATA_W(DATA_W), .DEG(POLY_DEG)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .din_valid(din_valid),
    .clr(clr), .shift(shift), .feed_zero(feed_zero),
    .last_flush(last_flush), .phase(phase)
  );

  assign line_in = feed_zero ? 1'b0 : din;

  cme_tapline #(.DEG(POLY_DEG), .GEN(GEN_POLY)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .shift(shift),
    .bit_in(line_in), .bit_out(tap_out), .dly(dly)
  );

  assign code_valid = shift;
  assign code_out   = shift & tap_out;

  // R8: after the last flush shift every data bit has left the chain
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (last_flush && !start) |=> (dly == '0));

  // R5: a stalled data cycle leaves the delay chain untouched
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_DATA && !din_valid && !start) |=> $stable(dly));

  // R2: the chain is empty on the first cycle of every word
  p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> (dly == '0));

  // R6: idle cycles never present a codeword bit
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (phase == PH_IDLE) |-> !code_valid);
endmodule

// File: tb/tb_cyc_mul_enc.sv
module tb_cyc_mul_enc;
  localparam int  CLK_PERIOD = 10;
  localparam int  DW  = 11;
  localparam int  CWL = 15;
  localparam logic [4:0] G = 5'b11001;

  logic clk = 1'b0;
  logic rst_n, start, din, din_valid;
  logic code_out, code_valid;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int          m_ph = 0;   // 0 idle, 1 data, 2 flush
  int          m_cnt = 0, m_oi = 0;
  logic [14:0] m_prod = '0, obs = '0;
  logic [10:0] cur_word = '0;
  bit          word_done = 0;

  cyc_mul_enc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .din_valid(din_valid), .code_out(code_out), .code_valid(code_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [14:0] clmul(input logic [10:0] w);
    logic [14:0] p = '0;
    for (int i = 0; i < DW; i++) if (w[i]) p = p ^ (15'(G) << i);
    return p;
  endfunction

  function automatic logic [4:0] pmod(input logic [14:0] c);
    logic [14:0] r = c;
    for (int i = 14; i >= 4; i--) if (r[i]) r = r ^ (15'(G) << (i - 4));
    return r[4:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare before the rising edge, advance model
  task automatic step(input logic s, input logic d, input logic dv);
    logic ev, eo;
    @(negedge clk);
    start = s; din = d; din_valid = dv;
    #(CLK_PERIOD/4);
    ev = !s && ((m_ph == 1 && dv) || m_ph == 2);
    eo = ev ? m_prod[m_oi] : 1'b0;
    check("R4/R5/R6/R7 code_valid", int'(code_valid), int'(ev));
    check(ev ? "R3 code_out" : "R10 code_out idle", int'(code_out), int'(eo));
    if (code_valid && m_oi < CWL) obs[m_oi] = code_out;
    word_done = 0;
    if (s) begin
      m_ph = 1; m_cnt = 0; m_oi = 0; m_prod = clmul(cur_word); obs = '0;
    end else if (m_ph == 1 && dv) begin
      m_oi++;
      if (m_cnt == DW - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
    end else if (m_ph == 2) begin
      m_oi++;
      if (m_cnt == 3) begin m_ph = 0; m_cnt = 0; word_done = 1; end else m_cnt++;
    end
  endtask

  task automatic check_rot();
    logic [14:0] r = obs;
    for (int k = 0; k < CWL; k++) begin
      check("R8 rotation remainder", int'(pmod(r)), 0);
      r = {r[13:0], r[14]};
    end
  endtask

  // full word; gap_mask bit i inserts a stalled cycle before data bit i
  task automatic send_word(input logic [10:0] w, input logic [10:0] gap_mask);
    cur_word = w;
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < DW; i++) begin
      if (gap_mask[i]) step(1'b0, ~w[i], 1'b0);   // R5 stall with junk din
      step(1'b0, w[i], 1'b1);
    end
    for (int f = 0; f < 4; f++) step(1'b0, 1'b1, 1'b1);  // R6 flush ignores din
    check("R4 word complete after 15 valid bits", int'(word_done), 1);
    check_rot();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [10:0] lf = 11'h2A5;
    rst_n = 1'b0; start = 1'b0; din = 1'b1; din_valid = 1'b1;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R1 reset code_valid", int'(code_valid), 0);
    check("R1 reset code_out", int'(code_out), 0);
    rst_n = 1'b1;
    // R1/R6: idle after reset, inputs toggling
    for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b1);

    // R9: stated codeword
    send_word(11'b10001100101, '0);
    check("R9 codeword", int'(obs), int'(15'b110000100011101));

    send_word(11'h000, '0);
    check("R3 zero word", int'(obs), 0);
    send_word(11'h7FF, '0);
    send_word(11'h400, '0);
    check("R3 single MSB", int'(obs), int'(15'(G) << 10));
    send_word(11'h001, '0);
    check("R3 single LSB", int'(obs), int'(G));

    // R5: stalls scattered through the word
    send_word(11'h5B3, 11'b10100110011);

    // R7/R2: abort after five ones, then a word whose low bits differ
    cur_word = 11'h7FF;
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);
    send_word(11'h010, '0);
    check("R2 restart codeword", int'(obs), int'(15'(G) << 4));

    // R6: idle with inputs active
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1);

    for (int n = 0; n < 4; n++) begin
      lf = {lf[9:0], lf[10] ^ lf[8]};
      send_word(lf, 11'(n * 37));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule